// File: doc/BRIEF.md
# Full-Bridge Gate Command Decoder

This block turns four control bits into the four gate-enable commands of a two-leg MOSFET H-bridge. Its inputs are a high-side PWM, a low-side PWM, a direction select and a synchronous-rectification enable. Together these choose between slow decay (chopping on the high or the low side), fast decay, dynamic braking and four-quadrant operation. The driving diagonal of the bridge is picked by the direction bit. The two PWM inputs switch that diagonal's high and low switch. When rectification is enabled, the other two switches conduct during the off-time of the switch they complement.

Each leg has a dead-time stage in front of its output registers, and both legs share one cycle-count setting. A switch that is asked to turn on soon after the other switch in its leg turned off is held back. The gap between the two is then exactly the programmed number of cycles. A switch whose partner has been off for longer than that window turns on with no extra delay. A setting of zero disables insertion. All four gate commands are registered, and the two switches of one leg are never on in the same cycle.

Top module: `hbridge_gate_decoder`

## Requirements
- R1: A synchronous active-high reset forces all four gate outputs to 0 at the next clock edge. Outside reset, the outputs respond to the inputs one clock edge later.
- R2: With dir_ab = 1 the driving pair is gate_a_hi and gate_b_lo. gate_a_hi follows pwm_hi, and gate_b_lo follows pwm_lo.
- R3: With dir_ab = 0 the driving pair is gate_b_hi and gate_a_lo. gate_b_hi follows pwm_hi, and gate_a_lo follows pwm_lo.
- R4: Each of the other two gates is 1 only when sync_rect = 1. It is then 1 exactly when the PWM input of the switch it complements in the same leg is 0. With sync_rect = 0 both of these gates stay 0.
- R5: The input pattern (pwm_hi, pwm_lo, dir_ab, sync_rect) = (0,1,x,1) turns both low gates on and both high gates off. The pattern (1,0,x,1) turns both high gates on and both low gates off. This is braking.
- R6: With pwm_hi = pwm_lo = sync_rect = 1, every toggle of dir_ab switches all four gates. The pair a_hi/b_lo is on when dir_ab = 1, and the pair b_hi/a_lo is on when dir_ab = 0.
- R7: Let D = dead_cycles be nonzero. When a gate is requested on at the same edge its leg partner turns off, or within D cycles after it, both gates of that leg stay 0 for exactly D clock cycles before the requested gate rises. The same setting applies to both legs.
- R8: If dead_cycles = 0, or if the partner gate has been off for at least D cycles, a requested gate rises one clock edge after the request, with no added delay.
- R9: In no cycle are the high and low gates of the same leg both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwm_hi | input | 1 | PWM for the high switch of the driving pair |
| pwm_lo | input | 1 | PWM for the low switch of the driving pair |
| dir_ab | input | 1 | 1: current A to B, 0: current B to A |
| sync_rect | input | 1 | Enables the complementary switches during off-time |
| dead_cycles | input | DT_W | Shared dead time in clock cycles, 0 disables |
| gate_a_hi | output | 1 | Leg A high-side gate command |
| gate_a_lo | output | 1 | Leg A low-side gate command |
| gate_b_hi | output | 1 | Leg B high-side gate command |
| gate_b_lo | output | 1 | Leg B low-side gate command |

## Verification
The hardest case to reach is a leg handover in which one switch turns off and its partner is requested at once. Only those cycles exercise the hold and the countdown. A handover happens only when an input change flips which switch of a leg is wanted, such as a direction toggle with rectification on, or a swap between the two braking patterns. The bench therefore walks every ordered pair of the sixteen input patterns under several dead-time settings. It settles on the first pattern, switches to the second, and compares every following cycle against a per-leg model of the gap.

// File: rtl/hbg_pkg.sv
package hbg_pkg;
  localparam int NUM_LEGS = 2;
  localparam int LEG_A = 0;
  localparam int LEG_B = 1;

  typedef struct packed {
    logic hi;
    logic lo;
  } leg_cmd_t;
endpackage

// File: rtl/hbg_mode_decode.sv
module hbg_mode_decode
  import hbg_pkg::*;
(
  input  logic     pwm_hi,
  input  logic     pwm_lo,
  input  logic     dir_ab,
  input  logic     sync_rect,
  output leg_cmd_t req [NUM_LEGS]
);
  logic drv_hi, drv_lo, cmp_hi, cmp_lo;

  always_comb begin
    drv_hi = pwm_hi;
    drv_lo = pwm_lo;
    // complementary switch of each driving switch conducts in its off-time
    cmp_lo = sync_rect & ~pwm_hi;
    cmp_hi = sync_rect & ~pwm_lo;
    if (dir_ab) begin
      req[LEG_A].hi = drv_hi;
      req[LEG_A].lo = cmp_lo;
      req[LEG_B].hi = cmp_hi;
      req[LEG_B].lo = drv_lo;
    end else begin
      req[LEG_B].hi = drv_hi;
      req[LEG_B].lo = cmp_lo;
      req[LEG_A].hi = cmp_hi;
      req[LEG_A].lo = drv_lo;
    end
  end
endmodule

// File: rtl/hbg_deadtime_leg.sv
module hbg_deadtime_leg
  import hbg_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DT_W-1:0] dead_cycles,
  input  leg_cmd_t        req,
  output leg_cmd_t        gate
);
  localparam logic [DT_W-1:0] CNT_ZERO = '0;
  localparam logic [DT_W-1:0] CNT_ONE  = {{(DT_W-1){1'b0}}, 1'b1};

  leg_cmd_t        gate_q, gate_n;
  logic [DT_W-1:0] cnt_q, cnt_n;
  logic            last_off_hi_q, last_off_hi_n;
  logic            dt_on, hi_off_now, lo_off_now, window, hold_hi, hold_lo;

  always_comb begin
    dt_on      = (dead_cycles != CNT_ZERO);
    hi_off_now = gate_q.hi & ~req.hi;
    lo_off_now = gate_q.lo & ~req.lo;
    window     = (cnt_q != CNT_ZERO);
    hold_hi    = dt_on & (lo_off_now | (window & ~last_off_hi_q));
    hold_lo    = dt_on & (hi_off_now | (window &  last_off_hi_q));
    gate_n.hi  = req.hi & ~hold_hi & ~req.lo;
    gate_n.lo  = req.lo & ~hold_lo & ~req.hi;
    cnt_n         = cnt_q;
    last_off_hi_n = last_off_hi_q;
    if (hi_off_now | lo_off_now) begin
      cnt_n         = dt_on ? (dead_cycles - CNT_ONE) : CNT_ZERO;
      last_off_hi_n = hi_off_now;
    end else if (window) begin
      cnt_n = cnt_q - CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_q        <= '0;
      cnt_q         <= '0;
      last_off_hi_q <= 1'b0;
    end else begin
      gate_q        <= gate_n;
      cnt_q         <= cnt_n;
      last_off_hi_q <= last_off_hi_n;
    end
  end

  assign gate = gate_q;

  // R9
  no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
    !(gate_q.hi && gate_q.lo));

  // R7
  lo_to_hi_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (dead_cycles != CNT_ZERO && gate_q.lo && !req.lo) |=> !gate_q.hi);

  // R7
  hi_to_lo_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (dead_cycles != CNT_ZERO && gate_q.hi && !req.hi) |=> !gate_q.lo);
endmodule

// File: rtl/hbridge_gate_decoder.sv
module hbridge_gate_decoder
  import hbg_pkg::*;
#(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwm_hi,
  input  logic            pwm_lo,
  input  logic            dir_ab,
  input  logic            sync_rect,
  input  logic [DT_W-1:0] dead_cycles,
  output logic            gate_a_hi,
  output logic            gate_a_lo,
  output logic            gate_b_hi,
  output logic            gate_b_lo
);
  leg_cmd_t req  [NUM_LEGS];
  leg_cmd_t gate [NUM_LEGS];

  hbg_mode_decode u_decode (
    .pwm_hi    (pwm_hi),
    .pwm_lo    (pwm_lo),
    .dir_ab    (dir_ab),
    .sync_rect (sync_rect),
    .req       (req)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    hbg_deadtime_leg #(.DT_W(DT_W)) u_leg (
      .clk         (clk),
      .rst         (rst),
      .dead_cycles (dead_cycles),
      .req         (req[g]),
      .gate        (gate[g])
    );
  end

  assign gate_a_hi = gate[LEG_A].hi;
  assign gate_a_lo = gate[LEG_A].lo;
  assign gate_b_hi = gate[LEG_B].hi;
  assign gate_b_lo = gate[LEG_B].lo;

  // R4
  no_sr_cmp_off_chk: assert property (@(posedge clk) disable iff (rst)
    (!sync_rect && dir_ab) |=> (!gate_a_lo && !gate_b_hi));

  // R2
  drive_pair_ab_chk: assert property (@(posedge clk) disable iff (rst)
    (dir_ab && !sync_rect && dead_cycles == '0) |=>
      (gate_a_hi == $past(pwm_hi) && gate_b_lo == $past(pwm_lo)));
endmodule

// File: tb/sim_hbridge_gate_decoder.sv
module sim_hbridge_gate_decoder;
  localparam int PERIOD = 10;
  localparam int DT_W   = 8;
  localparam int MAX_D  = 4;

  logic clk = 1'b0;
  logic rst, pwm_hi, pwm_lo, dir_ab, sync_rect;
  logic [DT_W-1:0] dead_cycles;
  logic gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  hbridge_gate_decoder #(.DT_W(DT_W)) u0 (
    .clk(clk), .rst(rst), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
    .dir_ab(dir_ab), .sync_rect(sync_rect), .dead_cycles(dead_cycles),
    .gate_a_hi(gate_a_hi), .gate_a_lo(gate_a_lo),
    .gate_b_hi(gate_b_hi), .gate_b_lo(gate_b_lo)
  );

  // pattern bits: [3]=pwm_hi [2]=pwm_lo [1]=dir_ab [0]=sync_rect
  // result bits:  [3]=a_hi [2]=a_lo [1]=b_hi [0]=b_lo
  function automatic logic [3:0] model(input logic [3:0] p);
    logic h, l, d, s, ah, al, bh, bl;
    h = p[3]; l = p[2]; d = p[1]; s = p[0];
    if (d) begin ah = h; bl = l; al = s & !h; bh = s & !l; end
    else   begin bh = h; al = l; bl = s & !h; ah = s & !l; end
    return {ah, al, bh, bl};
  endfunction

  function automatic logic [3:0] gates();
    return {gate_a_hi, gate_a_lo, gate_b_hi, gate_b_lo};
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: gates=%b expected=%b", tag, got, exp);
    end
  endtask

  task automatic drive(input logic [3:0] p);
    {pwm_hi, pwm_lo, dir_ab, sync_rect} = p;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    finish_run();
  end

  initial begin
    rst = 1'b1; drive(4'b0000); dead_cycles = '0;
    repeat (3) @(negedge clk);
    check("R1 reset", gates(), 4'b0000);
    rst = 1'b0;

    // R2..R5 directed patterns, dead time off, one-edge latency (R8)
    drive(4'b0110); @(negedge clk); check("R2 leg B low only", gates(), 4'b0001);
    drive(4'b0010); @(negedge clk); check("R2 all off", gates(), 4'b0000);
    drive(4'b1110); @(negedge clk); check("R2 A-hi B-lo drive", gates(), 4'b1001);
    drive(4'b1100); @(negedge clk); check("R3 B-hi A-lo drive", gates(), 4'b0110);
    drive(4'b1000); @(negedge clk); check("R4 no SR complement", gates(), 4'b0010);
    drive(4'b0111); @(negedge clk); check("R5 brake low", gates(), 4'b0101);
    drive(4'b1011); @(negedge clk); check("R5 brake high", gates(), 4'b1010);
    drive(4'b0101); @(negedge clk); check("R5 brake low dir0", gates(), 4'b0101);

    // R6 four-quadrant toggling
    for (int i = 0; i < 6; i++) begin
      drive({3'b110, 1'b1} | {2'b00, i[0], 1'b0});
      @(negedge clk);
      check("R6 four-quadrant", gates(), i[0] ? 4'b1001 : 4'b0110);
    end

    // R1 reset while gates are driven
    drive(4'b1110); @(negedge clk);
    rst = 1'b1; @(negedge clk);
    check("R1 reset mid-run", gates(), 4'b0000);
    rst = 1'b0;

    // R7/R8/R9 sweep over all ordered pattern pairs and dead times
    for (int d = 0; d <= MAX_D; d++) begin
      dead_cycles = DT_W'(d);
      for (int f = 0; f < 16; f++) begin
        for (int t = 0; t < 16; t++) begin
          logic [3:0] fg, tr, ex;
          string tag;
          drive(4'(f));
          repeat (d + 3) @(negedge clk);
          fg = model(4'(f));
          tr = model(4'(t));
          check("R2 settled pattern", gates(), fg);
          drive(4'(t));
          for (int k = 1; k <= d + 2; k++) begin
            @(negedge clk);
            tag = "R8 direct";
            // leg A
            ex[3] = tr[3] && !(d > 0 && fg[2] && k < d + 1);
            ex[2] = tr[2] && !(d > 0 && fg[3] && k < d + 1);
            ex[1] = tr[1] && !(d > 0 && fg[0] && k < d + 1);
            ex[0] = tr[0] && !(d > 0 && fg[1] && k < d + 1);
            if (ex != tr) tag = "R7 gap held";
            else if (d > 0 && ((tr[3] && fg[2]) || (tr[2] && fg[3]) ||
                               (tr[1] && fg[0]) || (tr[0] && fg[1])))
              tag = "R7 gap release";
            check(tag, gates(), ex);
            checks++;
            if ((gate_a_hi && gate_a_lo) || (gate_b_hi && gate_b_lo)) begin
              errors++;
              $display("FAIL R9: gates=%b expected no leg overlap", gates());
            end
          end
        end
      end
    end

    // R7 re-request of the same switch inside the window gets no gap
    dead_cycles = DT_W'(4);
    drive(4'b1110); repeat (8) @(negedge clk);
    drive(4'b0110); @(negedge clk);
    drive(4'b1110); @(negedge clk);
    check("R7 same-side reon", gates(), 4'b1001);

    finish_run();
  end
endmodule